// File: doc/BRIEF.md
# Flag-Gated Acquisition Sample Buffer

This block is a single-clock first-in first-out store that sits between a converter sample stream and a processor reader. Each word is 16 bits wide, and the store holds 4096 words. Three occupancy flags tell the reader when to act: empty, half-full and full. Unlike a free-running buffer, the block decides which side may move on each cycle from its own fill level. While the store is less than half full, only the writer is served and read requests are ignored. From half-full upward, a read and a write may both complete in the same cycle. Once the store is full, only the reader is served. A write that arrives while the store is full is dropped and latches a sticky overflow indication.

A small state machine holds the access policy. It has three states:
- **FILL**: occupancy is below 2048. Writes are served and reads are ignored.
- **SHARE**: occupancy is from 2048 to 4095. Writes and reads are both served.
- **FULL**: occupancy is 4096. Reads are served and writes are dropped.

The state machine has four transitions:
- **FILL→SHARE**: a write lifts occupancy to 2048.
- **SHARE→FULL**: a write with no read lifts occupancy to 4096.
- **FULL→SHARE**: any read is accepted while full.
- **SHARE→FILL**: a read with no write drops occupancy to 2047.

Read data is registered. It appears one cycle after the request is accepted, together with a one-cycle valid pulse.

Top module: `acq_buf_fifo`

## Requirements
- R1: While reset is held, and directly after reset, the outputs are: empty=1, half_full=0, full=0, overflow=0 and rd_valid=0.
- R2: `empty` is 1 exactly when the occupancy is 0.
- R3: `half_full` is 1 exactly when the occupancy is 2048 or more.
- R4: `full` is 1 exactly when the occupancy is 4096. The occupancy never goes above 4096 or below 0.
- R5: A read request while the occupancy is below 2048 is ignored. This includes the empty case. No `rd_valid` follows, and no stored word is removed.
- R6: When the occupancy is 2048 to 4095, a read and a write requested in the same cycle both complete, and the occupancy does not change.
- R7: When the occupancy is 4096, a write is dropped and a read in the same cycle still completes.
- R8: A dropped write sets `overflow`. It stays set until `ovf_clr` is high with no dropped write in that cycle. A dropped write and `ovf_clr` in the same cycle leave it set.
- R9: An accepted read gives `rd_valid`=1 on the following cycle, with `rd_data` carrying the oldest stored word. Words come out in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request carrying `wr_data` |
| wr_data | input | 16 | Sample to store |
| ovf_clr | input | 1 | Clears the sticky overflow bit |
| overflow | output | 1 | Sticky: a write was dropped while full |
| rd_req | input | 1 | Read request |
| rd_data | output | 16 | Word returned for the previous accepted read |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` |
| empty | output | 1 | Occupancy is 0 |
| half_full | output | 1 | Occupancy is 2048 or more |
| full | output | 1 | Occupancy is 4096 |

## Verification
The bench targets the two policy edges: occupancy 2047/2048 and occupancy 4096.
- **Read and write together at exactly 2048.** A design that serves only one side here lets `half_full` drop, or grows occupancy.
- **Reads below half-full.** A design that honours them produces an unexpected `rd_valid` and shifts the data order.
- **Writes at full.** If such a write is stored, an old word is overwritten and the read sequence breaks. If no overflow is latched, the sticky bit stays low.
- **Clear racing a dropped write.** This checks that a clear does not win over a new overflow.

// File: rtl/acq_buf_fifo_pkg.sv
package acq_buf_fifo_pkg;
    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_SHARE = 2'd1,
        ST_FULL  = 2'd2
    } acc_state_t;
endpackage

// File: rtl/acq_buf_ram.sv
module acq_buf_ram #(
    parameter int WIDTH = 16,
    parameter int AW    = 12
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    localparam int WORDS = 1 << AW;

    logic [WIDTH-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/acq_buf_ctrl.sv
module acq_buf_ctrl
    import acq_buf_fifo_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic          rd_req,
    input  logic          ovf_clr,
    output logic          wr_acc,
    output logic          rd_acc,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic          overflow,
    output logic          rd_valid,
    output logic          empty,
    output logic          half_full,
    output logic          full
);
    localparam int CW    = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam int HALF  = DEPTH / 2;

    acc_state_t    state, state_nx;
    logic [CW-1:0] count, count_nx;
    logic          drop;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_FILL;
        end else begin
            state <= state_nx;
        end
    end

    // outputs and next state
    always_comb begin
        wr_acc   = 1'b0;
        rd_acc   = 1'b0;
        drop     = 1'b0;
        unique case (state)
            ST_FILL: begin
                wr_acc = wr_valid;
            end
            ST_SHARE: begin
                wr_acc = wr_valid;
                rd_acc = rd_req;
            end
            ST_FULL: begin
                rd_acc = rd_req;
                drop   = wr_valid;
            end
            default: begin
                wr_acc = 1'b0;
            end
        endcase
        count_nx = count + CW'(wr_acc) - CW'(rd_acc);
        if (count_nx == CW'(DEPTH)) begin
            state_nx = ST_FULL;
        end else if (count_nx >= CW'(HALF)) begin
            state_nx = ST_SHARE;
        end else begin
            state_nx = ST_FILL;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= '0;
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            overflow <= 1'b0;
            rd_valid <= 1'b0;
        end else begin
            count    <= count_nx;
            rd_valid <= rd_acc;
            if (wr_acc) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (rd_acc) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            if (drop) begin
                overflow <= 1'b1;
            end else if (ovf_clr) begin
                overflow <= 1'b0;
            end
        end
    end

    assign empty     = (count == '0);
    assign half_full = (state != ST_FILL);
    assign full      = (state == ST_FULL);
endmodule

// File: rtl/acq_buf_fifo.sv
module acq_buf_fifo #(
    parameter int WIDTH = 16,
    parameter int AW    = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             ovf_clr,
    output logic             overflow,
    input  logic             rd_req,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid,
    output logic             empty,
    output logic             half_full,
    output logic             full
);
    logic          wr_acc, rd_acc;
    logic [AW-1:0] wr_ptr, rd_ptr;

    acq_buf_ctrl #(.AW(AW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .rd_req    (rd_req),
        .ovf_clr   (ovf_clr),
        .wr_acc    (wr_acc),
        .rd_acc    (rd_acc),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .overflow  (overflow),
        .rd_valid  (rd_valid),
        .empty     (empty),
        .half_full (half_full),
        .full      (full)
    );

    acq_buf_ram #(.WIDTH(WIDTH), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (wr_acc),
        .waddr (wr_ptr),
        .wdata (wr_data),
        .re    (rd_acc),
        .raddr (rd_ptr),
        .rdata (rd_data)
    );
endmodule

// File: rtl/acq_buf_fifo_chk.sv
module acq_buf_fifo_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_valid,
    input logic rd_req,
    input logic ovf_clr,
    input logic overflow,
    input logic rd_valid,
    input logic empty,
    input logic half_full,
    input logic full
);
    assert_full_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (half_full && !empty));

    assert_empty_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !half_full);

    assert_rd_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !half_full) |=> !rd_valid);

    assert_rd_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && half_full) |=> rd_valid);

    assert_share_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (half_full && !full && wr_valid && rd_req) |=> (half_full && !full));

    assert_full_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_valid && !rd_req) |=> full);

    assert_ovf_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_valid) |=> overflow);

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !ovf_clr) |=> overflow);
endmodule

bind acq_buf_fifo acq_buf_fifo_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .rd_req    (rd_req),
    .ovf_clr   (ovf_clr),
    .overflow  (overflow),
    .rd_valid  (rd_valid),
    .empty     (empty),
    .half_full (half_full),
    .full      (full)
);

// File: tb/acq_buf_fifo_bench.sv
module acq_buf_fifo_bench;
    localparam int DEPTH = 4096;
    localparam int HALF  = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_data = '0;
    logic        ovf_clr = 1'b0;
    logic        overflow;
    logic        rd_req = 1'b0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic        empty, half_full, full;

    int checks = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 1'b0;

    // reference model
    logic [15:0] q[$];
    bit          m_ovf = 1'b0;
    bit          m_rv = 1'b0;
    logic [15:0] m_rd = '0;
    logic [15:0] seq = 16'h0100;
    string       rv_tag = "R9";
    string       hf_tag = "R3";
    string       fu_tag = "R4";

    always #5 clk = ~clk;

    acq_buf_fifo u_acq_buf_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .ovf_clr   (ovf_clr),
        .overflow  (overflow),
        .rd_req    (rd_req),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .empty     (empty),
        .half_full (half_full),
        .full      (full)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    task automatic compare();
        chk("R2", 16'(empty), 16'(q.size() == 0), "empty");
        chk(hf_tag, 16'(half_full), 16'(q.size() >= HALF), "half_full");
        chk(fu_tag, 16'(full), 16'(q.size() == DEPTH), "full");
        chk("R8", 16'(overflow), 16'(m_ovf), "overflow");
        chk(rv_tag, 16'(rd_valid), 16'(m_rv), "rd_valid");
        if (m_rv) begin
            chk("R9", rd_data, m_rd, "rd_data");
        end
    endtask

    // one clock: check, drive, predict
    task automatic cyc(input bit w, input bit r, input bit c);
        int sz;
        bit wok, rok;
        @(negedge clk);
        compare();
        sz = q.size();
        wr_valid = w;
        rd_req   = r;
        ovf_clr  = c;
        wr_data  = seq;
        wok = (sz < DEPTH);
        rok = (sz >= HALF);
        rv_tag = (r && !rok) ? "R5" : "R9";
        hf_tag = (w && r && rok && wok && sz == HALF) ? "R6" : "R3";
        fu_tag = (w && !wok) ? "R7" : "R4";
        m_rv = r && rok;
        if (r && rok) begin
            m_rd = q.pop_front();
        end
        if (w && wok) begin
            q.push_back(seq);
        end
        if (w) begin
            seq = seq + 16'd1;
        end
        if (w && !wok) begin
            m_ovf = 1'b1;
        end else if (c) begin
            m_ovf = 1'b0;
        end
    endtask

    initial begin
        while (!finished) begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000) begin
                bad++;
                $display("FAIL watchdog expired actual=%0d expected<200000", cycles);
                $display("test done: total=%0d bad=%0d", checks, bad);
                $finish;
            end
        end
    end

    initial begin
        // R1: reset values while held
        repeat (3) @(negedge clk);
        chk("R1", 16'(empty), 16'd1, "empty in reset");
        chk("R1", 16'(half_full), 16'd0, "half_full in reset");
        chk("R1", 16'(full), 16'd0, "full in reset");
        chk("R1", 16'(overflow), 16'd0, "overflow in reset");
        chk("R1", 16'(rd_valid), 16'd0, "rd_valid in reset");
        rst_n = 1'b1;

        // R5: reads on empty store
        repeat (5) cyc(1'b0, 1'b1, 1'b0);
        // R5: reads ignored while filling
        repeat (100) cyc(1'b1, 1'b1, 1'b0);
        // fill to exactly half
        repeat (HALF - 100) cyc(1'b1, 1'b0, 1'b0);
        // R6: concurrent at the half boundary
        repeat (20) cyc(1'b1, 1'b1, 1'b0);
        // drop to 2047, then reads ignored
        cyc(1'b0, 1'b1, 1'b0);
        repeat (3) cyc(1'b0, 1'b1, 1'b0);
        // fill to full
        repeat (DEPTH - HALF + 1) cyc(1'b1, 1'b0, 1'b0);
        // R7/R8: writes at full
        repeat (5) cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 1'b0);
        cyc(1'b1, 1'b0, 1'b0);
        repeat (3) cyc(1'b1, 1'b1, 1'b0);
        cyc(1'b1, 1'b0, 1'b0);
        // R8: clear racing a dropped write, then plain clear
        cyc(1'b1, 1'b0, 1'b1);
        cyc(1'b0, 1'b0, 1'b1);
        cyc(1'b0, 1'b0, 1'b0);
        // random traffic
        for (int i = 0; i < 3000; i++) begin
            cyc(1'($urandom_range(0, 2) != 0), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 9) == 0));
        end
        // drain as far as policy allows, then more writes past the half mark and drain
        repeat (2500) cyc(1'b0, 1'b1, 1'b0);
        repeat (600) cyc(1'b1, 1'b0, 1'b0);
        repeat (800) cyc(1'b0, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        @(negedge clk);
        compare();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule